// File: doc/BRIEF.md
# Rename Stage Stall Controller

This block is the per-thread control state machine for the register-rename stage of an out-of-order pipeline. Each cycle it decides whether the stage renames incoming instructions, holds them in a skid buffer, drains that buffer, throws away in-flight work after a squash, or waits for the machine to go quiet before a serializing instruction may proceed. It does not rename operands. It only steers the flow around that work.

Its inputs are squash information from commit, block and unblock pulses from the downstream stage and from commit, a resource-full flag, the ROB-empty flag, the count of renamed instructions still in flight, a serialize-before flag for the head instruction, and the number of instructions that arrive from decode in this cycle. Its outputs are block and unblock pulses toward decode, and skid-buffer push, pop, clear and serialize re-insert strobes. It also drives the current state, the tracked skid-buffer occupancy, and a sticky overflow error.

The skid buffer holds at most `2*(DN_DELAY*DECODE_W)+RENAME_W` instructions, which is 12 with the default parameters. The state encoding is Idle=0, Running=1, Blocked=2, Unblocking=3, Squashing=4 and SerializeStall=5.

The transitions are named as follows:
- start (Idle→Running, when instructions arrive)
- stall (Idle/Running→Blocked)
- park (Idle/Running→SerializeStall)
- release (Blocked→Unblocking)
- restall (Unblocking→Blocked)
- drained (Unblocking→Running)
- squash (any state→Squashing)
- resume (Squashing→Running)
- serialize release (SerializeStall→Unblocking)

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset the state is Idle (0), the skid level is 0, and the pulse outputs and the error are low. Idle stays Idle while no instruction arrives, and it moves to Running (1) when `in_count_i` is non-zero.
- R2: A squash overrides everything else. The next state is Squashing (4) and `skid_clear_o` is asserted, so the level becomes 0. `up_unblock_o` pulses in that cycle only if the current state is Blocked (2), Unblocking (3) or SerializeStall (5).
- R3: Squashing stays in Squashing while `rob_squashing_i` is high or a stall is present. Otherwise it goes to Running in the next cycle.
- R4: Each block pulse from downstream or commit sets a sticky stall flag, and the matching unblock pulse clears it. Both take effect in the cycle of the pulse. A stall is present when either flag is set or `res_stall_i` is high.
- R5: A stall in Idle or Running pushes the arriving instructions, pulses `up_block_o` and moves to Blocked. Blocked and Unblocking never pulse `up_block_o`. A stall in Unblocking moves back to Blocked and pushes the arrivals.
- R6: SerializeStall never moves to Blocked, whatever stall is present. Arrivals in that state are pushed.
- R7: Blocked moves to Unblocking in the first cycle without a stall. While the level is non-zero and no stall is present, Unblocking pops min(level, RENAME_W) entries each cycle and pushes the arrivals. When the level is 0 it moves to Running and pulses `up_unblock_o`.
- R8: If instructions arrive in Idle or Running with no stall and `ser_head_i` high, the state moves to SerializeStall. This pulses `up_block_o` and pushes all arrivals except the serializing one. The state is released to Unblocking only when `rob_empty_i` is high, `inflight_i` is 0 and no stall is present. On release `ser_reinsert_o` pulses, and the held instruction adds 1 to the level only if the skid buffer is non-empty (otherwise it goes to the input queue).
- R9: If a cycle's update would take the level above the capacity, the level saturates at the capacity and `skid_ovf_o` is set. The error stays set until reset, including across a squash.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| squash_i | input | 1 | Squash request from commit |
| rob_squashing_i | input | 1 | ROB is still discarding squashed entries |
| dn_block_i | input | 1 | Block pulse from downstream stage |
| dn_unblock_i | input | 1 | Unblock pulse from downstream stage |
| cm_block_i | input | 1 | Block pulse from commit |
| cm_unblock_i | input | 1 | Unblock pulse from commit |
| res_stall_i | input | 1 | No free ROB, queue or register entries |
| rob_empty_i | input | 1 | ROB holds no instructions |
| inflight_i | input | INFL_W | Renamed instructions not yet dispatched |
| ser_head_i | input | 1 | Head arrival must serialize before itself |
| in_count_i | input | $clog2(DECODE_W+1) | Instructions arriving from decode this cycle |
| up_block_o | output | 1 | Block pulse toward decode |
| up_unblock_o | output | 1 | Unblock pulse toward decode |
| skid_push_o | output | 1 | Arrivals are written into the skid buffer |
| skid_pop_o | output | 1 | Skid buffer head entries are consumed |
| skid_clear_o | output | 1 | Skid buffer is flushed |
| ser_reinsert_o | output | 1 | Parked serializing instruction returns to the head |
| state_o | output | 3 | Current state encoding |
| skid_level_o | output | $clog2(SKID_MAX+1) | Tracked skid-buffer occupancy |
| skid_ovf_o | output | 1 | Sticky skid overflow error |

## Verification
The hardest situation to reach is a serialize stall that holds a non-empty skid buffer while a downstream block arrives and the drain condition is only partly met. Each of these has to be held off in turn, so that both the never-Blocked rule and the head re-insertion are visible in the level. The stimulus gets there in steps. It first parks the stage with the ROB non-empty and instructions in flight. It then raises a downstream block while more instructions arrive. Next it lifts the block with instructions still in flight. Only after that does it satisfy the drain condition. A second pass releases with an empty skid buffer, to show that the re-inserted instruction is not counted.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_RUN      = 3'd1,
        ST_BLOCKED  = 3'd2,
        ST_UNBLOCK  = 3'd3,
        ST_SQUASH   = 3'd4,
        ST_SER      = 3'd5
    } rsc_state_e;

    function automatic int skid_capacity(input int dn_delay, input int dec_w, input int ren_w);
        return 2 * (dn_delay * dec_w) + ren_w;
    endfunction

endpackage

// File: rtl/rsc_stall_flags.sv
module rsc_stall_flags #(
    parameter int NSRC = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] set_i,
    input  logic [NSRC-1:0] clr_i,
    output logic [NSRC-1:0] eff_o
);

    logic [NSRC-1:0] flag_q;

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        // a block pulse wins over a simultaneous unblock
        assign eff_o[k] = set_i[k] | (flag_q[k] & ~clr_i[k]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flag_q[k] <= 1'b0;
            else        flag_q[k] <= eff_o[k];
        end

        assert_flag_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            eff_o[k] |=> (eff_o[k] || clr_i[k]));
    end

endmodule

// File: rtl/rsc_skid_track.sv
module rsc_skid_track #(
    parameter int CAP   = 12,
    parameter int RW    = 4,
    parameter int LVL_W = 4,
    parameter int IN_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [IN_W-1:0]  push_amt_i,
    input  logic             pop_i,
    input  logic             reinsert_i,
    output logic [LVL_W-1:0] level_o,
    output logic             err_o
);

    localparam int SUM_W = LVL_W + IN_W + 1;

    logic [LVL_W-1:0] level_q;
    logic             err_q;
    logic [SUM_W-1:0] pop_n;
    logic [SUM_W-1:0] sum;
    logic             over;

    always_comb begin
        pop_n = '0;
        if (pop_i) begin
            pop_n = (SUM_W'(level_q) < SUM_W'(RW)) ? SUM_W'(level_q) : SUM_W'(RW);
        end
        sum = SUM_W'(level_q) - pop_n + SUM_W'(push_amt_i)
            + SUM_W'(reinsert_i && (level_q != '0));
        over = !clear_i && (sum > SUM_W'(CAP));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q <= '0;
            err_q   <= 1'b0;
        end else begin
            if (clear_i)   level_q <= '0;
            else if (over) level_q <= LVL_W'(CAP);
            else           level_q <= sum[LVL_W-1:0];
            if (over) err_q <= 1'b1;
        end
    end

    assign level_o = level_q;
    assign err_o   = err_q;

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);
    assert_err_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_q) |-> $past(push_amt_i != '0 || reinsert_i));
    assert_clear_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (level_q == '0));

endmodule

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl
    import rsc_pkg::*;
#(
    parameter int DN_DELAY = 1,
    parameter int DECODE_W = 4,
    parameter int RENAME_W = 4,
    parameter int INFL_W   = 6,
    localparam int SKID_MAX = 2 * (DN_DELAY * DECODE_W) + RENAME_W,
    localparam int LVL_W    = $clog2(SKID_MAX + 1),
    localparam int IN_W     = $clog2(DECODE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              squash_i,
    input  logic              rob_squashing_i,
    input  logic              dn_block_i,
    input  logic              dn_unblock_i,
    input  logic              cm_block_i,
    input  logic              cm_unblock_i,
    input  logic              res_stall_i,
    input  logic              rob_empty_i,
    input  logic [INFL_W-1:0] inflight_i,
    input  logic              ser_head_i,
    input  logic [IN_W-1:0]   in_count_i,
    output logic              up_block_o,
    output logic              up_unblock_o,
    output logic              skid_push_o,
    output logic              skid_pop_o,
    output logic              skid_clear_o,
    output logic              ser_reinsert_o,
    output logic [2:0]        state_o,
    output logic [LVL_W-1:0]  skid_level_o,
    output logic              skid_ovf_o
);

    localparam int CAP = skid_capacity(DN_DELAY, DECODE_W, RENAME_W);

    rsc_state_e      st_q, st_d;
    logic [1:0]      flag_eff;
    logic            stall;
    logic            drained;
    logic [IN_W-1:0] push_amt;
    logic            pop_req;
    logic            clear;
    logic            reinsert;
    logic [LVL_W-1:0] level;

    rsc_stall_flags #(.NSRC(2)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i ({cm_block_i, dn_block_i}),
        .clr_i ({cm_unblock_i, dn_unblock_i}),
        .eff_o (flag_eff)
    );

    rsc_skid_track #(.CAP(CAP), .RW(RENAME_W), .LVL_W(LVL_W), .IN_W(IN_W)) u_skid (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .push_amt_i (push_amt),
        .pop_i      (pop_req),
        .reinsert_i (reinsert),
        .level_o    (level),
        .err_o      (skid_ovf_o)
    );

    assign stall   = (|flag_eff) | res_stall_i;
    assign drained = rob_empty_i && (inflight_i == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d         = st_q;
        up_block_o   = 1'b0;
        up_unblock_o = 1'b0;
        push_amt     = '0;
        pop_req      = 1'b0;
        clear        = 1'b0;
        reinsert     = 1'b0;
        if (squash_i) begin
            st_d         = ST_SQUASH;
            clear        = 1'b1;
            up_unblock_o = (st_q == ST_BLOCKED) || (st_q == ST_UNBLOCK) || (st_q == ST_SER);
        end else begin
            unique case (st_q)
                ST_IDLE, ST_RUN: begin
                    if (stall) begin
                        up_block_o = 1'b1;
                        push_amt   = in_count_i;
                        st_d       = ST_BLOCKED;
                    end else if (in_count_i != '0 && ser_head_i) begin
                        up_block_o = 1'b1;
                        push_amt   = in_count_i - IN_W'(1);
                        st_d       = ST_SER;
                    end else if (in_count_i != '0) begin
                        st_d = ST_RUN;
                    end
                end
                ST_BLOCKED: begin
                    push_amt = in_count_i;
                    if (!stall) st_d = ST_UNBLOCK;
                end
                ST_UNBLOCK: begin
                    if (stall) begin
                        push_amt = in_count_i;
                        st_d     = ST_BLOCKED;
                    end else if (level == '0) begin
                        up_unblock_o = 1'b1;
                        st_d         = ST_RUN;
                    end else begin
                        pop_req  = 1'b1;
                        push_amt = in_count_i;
                    end
                end
                ST_SQUASH: begin
                    if (!rob_squashing_i && !stall) st_d = ST_RUN;
                end
                ST_SER: begin
                    push_amt = in_count_i;
                    if (drained && !stall) begin
                        reinsert = 1'b1;
                        st_d     = ST_UNBLOCK;
                    end
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    assign skid_push_o    = (push_amt != '0);
    assign skid_pop_o     = pop_req;
    assign skid_clear_o   = clear;
    assign ser_reinsert_o = reinsert;
    assign state_o        = st_q;
    assign skid_level_o   = level;

    assert_squash_enters_R2: assert property (@(posedge clk) disable iff (!rst_n)
        squash_i |=> (state_o == 3'd4));
    assert_squash_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && rob_squashing_i && !squash_i) |=> (state_o == 3'd4));
    assert_block_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        up_block_o |=> !up_block_o);
    assert_ser_no_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd5 && !squash_i) |=> (state_o != 3'd2));
    assert_unblock_drained_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (up_unblock_o && !squash_i) |-> (skid_level_o == '0));

endmodule

// File: tb/test_rename_stall_ctrl.sv
module test_rename_stall_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 29;
    localparam int VW = 30;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       squash_i = 0, rob_squashing_i = 0;
    logic       dn_block_i = 0, dn_unblock_i = 0, cm_block_i = 0, cm_unblock_i = 0;
    logic       res_stall_i = 0, rob_empty_i = 1;
    logic [5:0] inflight_i = '0;
    logic       ser_head_i = 0;
    logic [2:0] in_count_i = '0;
    logic       up_block_o, up_unblock_o, skid_push_o, skid_pop_o, skid_clear_o, ser_reinsert_o;
    logic [2:0] state_o;
    logic [3:0] skid_level_o;
    logic       skid_ovf_o;

    int n_checks = 0;
    int n_fail = 0;

    rename_stall_ctrl i_rename_stall_ctrl (
        .clk(clk), .rst_n(rst_n), .squash_i(squash_i), .rob_squashing_i(rob_squashing_i),
        .dn_block_i(dn_block_i), .dn_unblock_i(dn_unblock_i), .cm_block_i(cm_block_i),
        .cm_unblock_i(cm_unblock_i), .res_stall_i(res_stall_i), .rob_empty_i(rob_empty_i),
        .inflight_i(inflight_i), .ser_head_i(ser_head_i), .in_count_i(in_count_i),
        .up_block_o(up_block_o), .up_unblock_o(up_unblock_o), .skid_push_o(skid_push_o),
        .skid_pop_o(skid_pop_o), .skid_clear_o(skid_clear_o), .ser_reinsert_o(ser_reinsert_o),
        .state_o(state_o), .skid_level_o(skid_level_o), .skid_ovf_o(skid_ovf_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // fields: req | sq rsq dnb dnu cmb cmu rs re | inflight | ser | in_count | blk unb | state | level
    localparam logic [VW-1:0] VEC [NVEC] = '{
        {4'd1, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd0, 5'd0},  // R1 idle holds
        {4'd1, 8'b0000_0001, 4'd0, 1'b0, 3'd2, 2'b00, 3'd1, 5'd0},  // R1 start
        {4'd5, 8'b0010_0001, 4'd0, 1'b0, 3'd4, 2'b10, 3'd2, 5'd4},  // R5 stall
        {4'd4, 8'b0000_0001, 4'd0, 1'b0, 3'd3, 2'b00, 3'd2, 5'd7},  // R4 sticky flag
        {4'd7, 8'b0001_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd7},  // R7 release
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd2, 2'b00, 3'd3, 5'd5},  // R7 pop 4 push 2
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd1},
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd0},  // R7 partial pop
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b01, 3'd1, 5'd0},  // R7 drained
        {4'd5, 8'b0000_1001, 4'd0, 1'b0, 3'd1, 2'b10, 3'd2, 5'd1},  // R5 commit block
        {4'd4, 8'b0000_0111, 4'd0, 1'b0, 3'd0, 2'b00, 3'd2, 5'd1},  // R4 resource stall
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd1},
        {4'd5, 8'b0000_0011, 4'd0, 1'b0, 3'd0, 2'b00, 3'd2, 5'd1},  // R5 restall
        {4'd2, 8'b1000_0001, 4'd0, 1'b0, 3'd0, 2'b01, 3'd4, 5'd0},  // R2 squash from blocked
        {4'd3, 8'b0100_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd4, 5'd0},  // R3 rob squashing
        {4'd3, 8'b0000_0011, 4'd0, 1'b0, 3'd0, 2'b00, 3'd4, 5'd0},  // R3 stall holds
        {4'd3, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd1, 5'd0},  // R3 resume
        {4'd8, 8'b0000_0000, 4'd2, 1'b1, 3'd3, 2'b10, 3'd5, 5'd2},  // R8 park
        {4'd6, 8'b0010_0000, 4'd2, 1'b0, 3'd1, 2'b00, 3'd5, 5'd3},  // R6 block ignored
        {4'd8, 8'b0001_0001, 4'd2, 1'b0, 3'd0, 2'b00, 3'd5, 5'd3},  // R8 inflight waits
        {4'd8, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd4},  // R8 reinsert to skid
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd0},
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b01, 3'd1, 5'd0},
        {4'd8, 8'b0000_0000, 4'd0, 1'b1, 3'd1, 2'b10, 3'd5, 5'd0},  // R8 park alone
        {4'd2, 8'b1000_0000, 4'd0, 1'b0, 3'd0, 2'b01, 3'd4, 5'd0},  // R2 squash from ser
        {4'd3, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd1, 5'd0},
        {4'd8, 8'b0000_0001, 4'd0, 1'b1, 3'd1, 2'b10, 3'd5, 5'd0},
        {4'd8, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b00, 3'd3, 5'd0},  // R8 reinsert to queue
        {4'd7, 8'b0000_0001, 4'd0, 1'b0, 3'd0, 2'b01, 3'd1, 5'd0}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic [7:0] c, input logic [3:0] inf, input logic ser, input logic [2:0] cnt);
        {squash_i, rob_squashing_i, dn_block_i, dn_unblock_i,
         cm_block_i, cm_unblock_i, res_stall_i, rob_empty_i} = c;
        inflight_i = 6'(inf);
        ser_head_i = ser;
        in_count_i = cnt;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        repeat (2) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk("R1", "state", state_o, 0);
        chk("R1", "level", skid_level_o, 0);
        chk("R1", "pulses", {up_block_o, up_unblock_o, skid_ovf_o}, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            logic [VW-1:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("R%0d vec%0d", v[29:26], i);
            @(negedge clk);
            drive(v[25:18], v[17:14], v[13], v[12:10]);
            #1;
            chk(tag, "up_block", up_block_o, v[9]);
            chk(tag, "up_unblock", up_unblock_o, v[8]);
            @(posedge clk);
            #1;
            chk(tag, "state", state_o, v[7:5]);
            chk(tag, "level", skid_level_o, v[4:0]);
        end

        // R9 overflow: fill past capacity 12 while blocked
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            drive((k == 0) ? 8'b0010_0001 : 8'b0000_0001, 4'd0, 1'b0, 3'd4);
            @(posedge clk);
            #1;
            chk("R9", "ovf", skid_ovf_o, (k == 3) ? 1 : 0);
            chk("R9", "level", skid_level_o, (k == 3) ? 12 : 4 * (k + 1));
        end
        @(negedge clk);
        drive(8'b1000_0001, 4'd0, 1'b0, 3'd0);
        @(posedge clk);
        #1;
        chk("R9", "ovf after squash", skid_ovf_o, 1);
        chk("R2", "level after squash", skid_level_o, 0);

        // R1 reset clears everything
        @(negedge clk);
        drive(8'b0000_0001, 4'd0, 1'b0, 3'd0);
        rst_n = 1'b0;
        #1;
        chk("R1", "ovf reset", skid_ovf_o, 0);
        chk("R1", "state reset", state_o, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule